// File: doc/BRIEF.md
# Microwire Half-Duplex Serial Master

This block is a serial master for the Microwire frame format. Software or a neighbouring block writes 8-bit control bytes into a small transmit queue. Each byte starts a frame. The master lowers an active-low chip select and shifts the control byte out MSB first. It then inserts one idle serial clock. After that it captures a 4- to 16-bit response from the slave and pushes the response word into a receive queue.

The serial clock is derived from the system clock by a programmable even divisor. The response length is programmed as bit count minus one. Response length and divisor are latched at the start of each frame. In continuous mode, further queued control bytes follow the previous response with no gap, and chip select stays low between them. Otherwise chip select returns high after every frame.

Top module: `mw_master`

## Requirements
- R1: While idle, cs_no is 1, sclk_o is 0 and sdo_o is 0.
- R2: When the transmit queue holds a byte and the receive queue is not full, cs_no falls with sclk_o at 0 and sdo_o already showing bit 7 of the oldest queued byte.
- R3: The 8 control bits leave MSB first. sdo_o changes only while sclk_o is low, so the slave latches each bit on a rising sclk_o edge.
- R4: A frame has exactly 9+N rising sclk_o edges. The ninth rising edge is a wait slot with sdo_o at 0, and nothing is captured during it.
- R5: cfg_len_i holds N-1. A value below 3 gives N=4, so N ranges from 4 to 16.
- R6: Response bits are sampled on the rising sclk_o edges after the wait slot, MSB first. The word appears on rx_data_o right-aligned, with the bits above N at zero.
- R7: Each sclk_o half period lasts cfg_div_i/2 system clock cycles, with bit 0 of cfg_div_i ignored. A divisor below 2 acts as 2.
- R8: The received word is pushed into the receive queue on the sclk_o falling edge that follows the last response sample. In a single transfer, cs_no rises one full serial clock period (two half periods) after that last sample.
- R9: With cfg_cont_i at 1, the next control byte begins right after that falling edge, with cs_no held low, if the transmit queue is not empty and the receive queue was not full before the push. Otherwise the frame ends as in R8.
- R10: busy_o is 1 exactly while cs_no is 0.
- R11: No frame starts from idle while the receive queue is full.
- R12: A word that completes while the receive queue is full is dropped, and overrun_o becomes 1 and stays 1 until reset.
- R13: tx_ready_o is 1 when the transmit queue has space. rx_valid_o and rx_data_o hold until rx_ready_i accepts the word, and rx_valid_o is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_data_i | input | 8 | Control byte to queue |
| tx_valid_i | input | 1 | Control byte write strobe |
| tx_ready_o | output | 1 | Transmit queue has space |
| rx_data_o | output | 16 | Oldest received word, right-aligned |
| rx_valid_o | output | 1 | Receive queue not empty |
| rx_ready_i | input | 1 | Consume the oldest received word |
| cfg_len_i | input | 4 | Response length minus one |
| cfg_div_i | input | 8 | System cycles per serial clock period |
| cfg_cont_i | input | 1 | Chain frames under a held chip select |
| sclk_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| sdo_o | output | 1 | Serial data to the slave |
| sdi_i | input | 1 | Serial data from the slave |
| busy_o | output | 1 | Frame in progress |
| overrun_o | output | 1 | Sticky dropped-word flag |

## Verification
Single frames are run with distinct control bytes at the shortest, a middle and the longest response length, and with a length code below the minimum. Each response depends on its control byte, so a wrong bit order, a wrong alignment or a lost first bit shows as a mismatch. Divisors of 0, 2, 4, 6 and 7 separate the minimum-divisor clamp and the ignored low bit from the normal half period. Three queued bytes are sent once with chaining and once without. Counting chip-select edges and clock edges then separates back-to-back frames from separate ones. A run that fills the receive queue separates the rule that blocks a new frame from the drop-and-flag rule for a frame already chained.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2
  } mw_state_e;

  localparam int CTRL_BITS = 8;
  localparam int MIN_RESP  = 4;
endpackage

// File: rtl/mw_fifo.sv
module mw_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
      if (do_pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/mw_clkgen.sv
module mw_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == half_i - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!en_i || tick_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/mw_seq.sv
module mw_seq
  import mw_pkg::*;
#(
  parameter int RESP_W = 16,
  parameter int DIV_W  = 8,
  localparam int LEN_W = $clog2(RESP_W),
  localparam int CNT_W = $clog2(CTRL_BITS + RESP_W + 2)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CTRL_BITS-1:0] tx_data_i,
  input  logic                 tx_empty_i,
  output logic                 tx_pop_o,
  input  logic                 rx_full_i,
  output logic                 rx_push_o,
  output logic [RESP_W-1:0]    rx_word_o,
  input  logic [LEN_W-1:0]     cfg_len_i,
  input  logic [DIV_W-1:0]     cfg_div_i,
  input  logic                 cfg_cont_i,
  input  logic                 sdi_i,
  input  logic                 tick_i,
  output logic                 run_o,
  output logic [DIV_W-1:0]     half_o,
  output logic                 sclk_o,
  output logic                 cs_no,
  output logic                 sdo_o,
  output logic                 busy_o,
  output logic                 overrun_o
);
  mw_state_e            state_q;
  logic [CNT_W-1:0]     bit_q, last_q, last_cfg;
  logic [CTRL_BITS-1:0] tx_sh_q;
  logic [RESP_W-1:0]    rx_sh_q;
  logic [DIV_W-1:0]     half_q, half_cfg, half_raw;
  logic [LEN_W-1:0]     len_eff;
  logic                 sclk_q, ovr_q;
  logic                 can_start, start_idle, rise, fall, frame_end, chain;

  // clamp length code and divisor
  assign len_eff  = (cfg_len_i < LEN_W'(MIN_RESP - 1)) ? LEN_W'(MIN_RESP - 1) : cfg_len_i;
  assign last_cfg = CNT_W'(CTRL_BITS + 1) + CNT_W'(len_eff);
  assign half_raw = cfg_div_i >> 1;
  assign half_cfg = (half_raw == '0) ? DIV_W'(1) : half_raw;

  assign can_start  = !tx_empty_i && !rx_full_i;
  assign start_idle = (state_q == ST_IDLE) && can_start;
  assign rise       = (state_q == ST_RUN) && tick_i && !sclk_q;
  assign fall       = (state_q == ST_RUN) && tick_i && sclk_q;
  assign frame_end  = fall && (bit_q == last_q);
  // fullness sampled before this frame's push
  assign chain      = frame_end && cfg_cont_i && can_start;

  assign tx_pop_o  = start_idle || chain;
  assign rx_push_o = frame_end;
  assign rx_word_o = rx_sh_q;
  assign run_o     = (state_q != ST_IDLE);
  assign half_o    = half_q;
  assign sclk_o    = sclk_q;
  assign cs_no     = (state_q == ST_IDLE);
  assign busy_o    = (state_q != ST_IDLE);
  assign sdo_o     = (state_q == ST_RUN) && (bit_q < CNT_W'(CTRL_BITS)) && tx_sh_q[CTRL_BITS-1];
  assign overrun_o = ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      last_q  <= '0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      half_q  <= DIV_W'(1);
      sclk_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (frame_end && rx_full_i) ovr_q <= 1'b1;
      case (state_q)
        ST_IDLE: begin
          sclk_q <= 1'b0;
          if (start_idle) begin
            state_q <= ST_RUN;
            bit_q   <= '0;
            tx_sh_q <= tx_data_i;
            rx_sh_q <= '0;
            last_q  <= last_cfg;
            half_q  <= half_cfg;
          end
        end
        ST_RUN: begin
          if (rise) begin
            sclk_q <= 1'b1;
            if (bit_q > CNT_W'(CTRL_BITS))
              rx_sh_q <= {rx_sh_q[RESP_W-2:0], sdi_i};
          end else if (fall) begin
            sclk_q <= 1'b0;
            if (frame_end) begin
              if (chain) begin
                bit_q   <= '0;
                tx_sh_q <= tx_data_i;
                rx_sh_q <= '0;
                last_q  <= last_cfg;
                half_q  <= half_cfg;
              end else begin
                state_q <= ST_TAIL;
              end
            end else begin
              bit_q <= bit_q + CNT_W'(1);
              if (bit_q < CNT_W'(CTRL_BITS)) tx_sh_q <= tx_sh_q << 1;
            end
          end
        end
        ST_TAIL: begin
          if (tick_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mw_master.sv
module mw_master
  import mw_pkg::*;
#(
  parameter int RESP_W  = 16,
  parameter int DIV_W   = 8,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  localparam int LEN_W  = $clog2(RESP_W)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CTRL_BITS-1:0] tx_data_i,
  input  logic                 tx_valid_i,
  output logic                 tx_ready_o,
  output logic [RESP_W-1:0]    rx_data_o,
  output logic                 rx_valid_o,
  input  logic                 rx_ready_i,
  input  logic [LEN_W-1:0]     cfg_len_i,
  input  logic [DIV_W-1:0]     cfg_div_i,
  input  logic                 cfg_cont_i,
  output logic                 sclk_o,
  output logic                 cs_no,
  output logic                 sdo_o,
  input  logic                 sdi_i,
  output logic                 busy_o,
  output logic                 overrun_o
);
  logic [CTRL_BITS-1:0] txq_data;
  logic                 txq_empty, txq_full, txq_pop;
  logic [RESP_W-1:0]    rx_word;
  logic                 rxq_empty, rxq_full, rxq_push;
  logic                 run, tick;
  logic [DIV_W-1:0]     half;

  assign tx_ready_o = !txq_full;
  assign rx_valid_o = !rxq_empty;

  mw_fifo #(.W(CTRL_BITS), .DEPTH(TX_DEPTH)) u_txq (
    .clk_i, .rst_ni,
    .push_i (tx_valid_i), .data_i (tx_data_i),
    .pop_i  (txq_pop),    .data_o (txq_data),
    .empty_o(txq_empty),  .full_o (txq_full)
  );

  mw_fifo #(.W(RESP_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk_i, .rst_ni,
    .push_i (rxq_push),   .data_i (rx_word),
    .pop_i  (rx_ready_i), .data_o (rx_data_o),
    .empty_o(rxq_empty),  .full_o (rxq_full)
  );

  mw_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk_i, .rst_ni, .en_i(run), .half_i(half), .tick_o(tick)
  );

  mw_seq #(.RESP_W(RESP_W), .DIV_W(DIV_W)) u_seq (
    .clk_i, .rst_ni,
    .tx_data_i (txq_data), .tx_empty_i(txq_empty), .tx_pop_o(txq_pop),
    .rx_full_i (rxq_full), .rx_push_o (rxq_push),  .rx_word_o(rx_word),
    .cfg_len_i, .cfg_div_i, .cfg_cont_i, .sdi_i,
    .tick_i(tick), .run_o(run), .half_o(half),
    .sclk_o, .cs_no, .sdo_o, .busy_o, .overrun_o
  );
endmodule

// File: rtl/mw_master_chk.sv
module mw_master_chk #(
  parameter int RESP_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tx_ready_o,
  input logic [RESP_W-1:0] rx_data_o,
  input logic              rx_valid_o,
  input logic              rx_ready_i,
  input logic              sclk_o,
  input logic              cs_no,
  input logic              sdo_o,
  input logic              busy_o,
  input logic              overrun_o
);
  a_r1_idle_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> (!sclk_o && !sdo_o));

  a_r2_start_clock_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> !sclk_o);

  a_r3_sdo_hold_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(sdo_o));

  a_r12_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);

  a_r13_rx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o)));
endmodule

bind mw_master mw_master_chk #(.RESP_W(RESP_W)) u_chk (.*);

// File: tb/mw_master_tb.sv
`timescale 1ns/1ps
module mw_master_tb;
  localparam int CLK_NS = 8;
  localparam int DEPTH  = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        tx_valid = 1'b0, tx_ready;
  logic [15:0] rx_data;
  logic        rx_valid, rx_ready = 1'b0;
  logic [3:0]  cfg_len = 4'd7;
  logic [7:0]  cfg_div = 8'd4;
  logic        cfg_cont = 1'b0;
  logic        sclk, cs_n, sdo, sdi = 1'b0, busy, overrun;

  int n_checks = 0, n_fail = 0, cyc = 0;

  always #(CLK_NS/2) clk = ~clk;

  mw_master u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready),
    .cfg_len_i(cfg_len), .cfg_div_i(cfg_div), .cfg_cont_i(cfg_cont),
    .sclk_o(sclk), .cs_no(cs_n), .sdo_o(sdo), .sdi_i(sdi),
    .busy_o(busy), .overrun_o(overrun)
  );

  // ---------------- slave model ----------------
  int          cur_n = 8;
  int          k = 0, rises = 0, cs_falls = 0, cs_rises = 0, nlog = 0;
  logic [7:0]  ctrl_cap = '0;
  logic [7:0]  ctrl_log [16];
  logic        wait_sdo = 1'b0;
  time         t_rise = 0, t_cs_hi = 0, hi_ns = 0;

  function automatic logic [15:0] resp_of(input logic [7:0] c, input int n);
    logic [15:0] v, m;
    v = {c, ~c} ^ 16'h3C5A;
    m = (n >= 16) ? 16'hFFFF : ((16'd1 << n) - 16'd1);
    return v & m;
  endfunction

  always @(negedge cs_n) begin k = 0; sdi = 1'b0; cs_falls++; end
  always @(posedge cs_n) begin t_cs_hi = $time; cs_rises++; end

  always @(posedge sclk) begin
    t_rise = $time;
    rises++;
    if (k < 8) ctrl_cap = {ctrl_cap[6:0], sdo};
    if (k == 8) wait_sdo = sdo;
    k++;
    if (k == 8) begin
      ctrl_log[nlog % 16] = ctrl_cap;
      nlog++;
    end
    if (k == 9 + cur_n) k = 0;
  end

  always @(negedge sclk) begin
    logic [15:0] r;
    hi_ns = $time - t_rise;
    r = resp_of(ctrl_cap, cur_n);
    if (k >= 9 && k < 9 + cur_n) sdi = r[cur_n - 1 - (k - 9)];
    else sdi = 1'b0;
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push_tx(input logic [7:0] b);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data  = b;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic pop_rx(output logic [15:0] w);
    @(negedge clk);
    while (!rx_valid) @(negedge clk);
    w = rx_data;
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic wait_cs_rises(input int tgt);
    while (cs_rises < tgt) @(negedge clk);
    @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    @(negedge clk);
    check("R1 idle cs", int'(cs_n), 1);
    check("R1 idle sclk", int'(sclk), 0);
    check("R1 idle sdo", int'(sdo), 0);
    check("R10 busy at reset", int'(busy), 0);
    check("R13 tx_ready at reset", int'(tx_ready), 1);
    check("R13 rx_valid at reset", int'(rx_valid), 0);
    check("R12 overrun at reset", int'(overrun), 0);
  endtask

  task automatic t_single(input logic [7:0] c, input logic [3:0] len,
                          input logic [7:0] div, input int n, input int h);
    logic [15:0] w;
    int r0, f0, l0;
    cfg_len = len; cfg_div = div; cfg_cont = 1'b0; cur_n = n;
    r0 = rises; f0 = cs_rises; l0 = nlog;
    push_tx(c);
    while (cs_n) @(negedge clk);
    check("R2 sdo shows MSB at cs fall", int'(sdo), int'(c[7]));
    check("R2 sclk low at cs fall", int'(sclk), 0);
    check("R10 busy during frame", int'(busy), 1);
    wait_cs_rises(f0 + 1);
    check("R10 busy after frame", int'(busy), 0);
    check("R1 sdo low after frame", int'(sdo), 0);
    check("R3 control byte seen by slave", int'(ctrl_log[l0 % 16]), int'(c));
    check("R4 rising edges per frame", rises - r0, 9 + n);
    check("R4 sdo low in wait slot", int'(wait_sdo), 0);
    check("R7 sclk high time", int'(hi_ns / CLK_NS), h);
    check("R8 cs rise after last sample", int'((t_cs_hi - t_rise) / CLK_NS), 2 * h);
    pop_rx(w);
    check("R5 R6 response word", int'(w), int'(resp_of(c, n)));
  endtask

  task automatic t_chain(input logic cont);
    logic [15:0] w;
    logic [7:0]  b [3];
    int r0, f0, fr0;
    b[0] = 8'h11; b[1] = 8'hC7; b[2] = 8'h6E;
    cfg_len = 4'd5; cfg_div = 8'd4; cfg_cont = cont; cur_n = 6;
    r0 = rises; f0 = cs_falls; fr0 = cs_rises;
    for (int i = 0; i < 3; i++) push_tx(b[i]);
    if (cont) wait_cs_rises(fr0 + 1);
    else wait_cs_rises(fr0 + 3);
    check("R9 rising edges for three frames", rises - r0, 3 * 15);
    check("R9 chip select falls", cs_falls - f0, cont ? 1 : 3);
    for (int i = 0; i < 3; i++) begin
      pop_rx(w);
      check("R9 chained word", int'(w), int'(resp_of(b[i], 6)));
    end
  endtask

  task automatic t_full_block();
    logic [15:0] w;
    int fr0;
    cfg_len = 4'd3; cfg_div = 8'd2; cfg_cont = 1'b0; cur_n = 4;
    fr0 = cs_rises;
    for (int i = 0; i < DEPTH; i++) begin
      push_tx(8'h20 + 8'(i));
      wait_cs_rises(fr0 + i + 1);
    end
    push_tx(8'h99);
    repeat (100) @(negedge clk);
    check("R11 no start while rx full (cs)", int'(cs_n), 1);
    check("R11 no start while rx full (busy)", int'(busy), 0);
    check("R11 tx byte still queued", cs_rises - fr0, DEPTH);
    pop_rx(w);
    check("R11 oldest word kept", int'(w), int'(resp_of(8'h20, 4)));
    wait_cs_rises(fr0 + DEPTH + 1);
    for (int i = 1; i < DEPTH; i++) pop_rx(w);
    pop_rx(w);
    check("R11 blocked frame runs after pop", int'(w), int'(resp_of(8'h99, 4)));
    check("R12 no overrun so far", int'(overrun), 0);
  endtask

  task automatic t_overrun();
    logic [15:0] w;
    int fr0, r0;
    cfg_len = 4'd3; cfg_div = 8'd4; cfg_cont = 1'b1; cur_n = 4;
    fr0 = cs_rises; r0 = rises;
    for (int i = 0; i < DEPTH + 1; i++) push_tx(8'h40 + 8'(i));
    wait_cs_rises(fr0 + 1);
    check("R12 chained frames ran", rises - r0, (DEPTH + 1) * 13);
    check("R12 overrun set", int'(overrun), 1);
    for (int i = 0; i < DEPTH; i++) begin
      pop_rx(w);
      check("R12 stored word", int'(w), int'(resp_of(8'h40 + 8'(i), 4)));
    end
    @(negedge clk);
    check("R12 dropped word absent", int'(rx_valid), 0);
    check("R12 overrun sticky", int'(overrun), 1);
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single(8'hA5, 4'd7,  8'd4, 8,  2);
    t_single(8'h3C, 4'd0,  8'd2, 4,  1);   // R5 clamp
    t_single(8'hF0, 4'd15, 8'd6, 16, 3);
    t_single(8'h81, 4'd4,  8'd0, 5,  1);   // R7 divisor clamp
    t_single(8'h5A, 4'd11, 8'd7, 12, 3);   // R7 low bit ignored
    t_chain(1'b1);
    t_chain(1'b0);
    t_full_block();
    t_overrun();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule